// File: doc/BRIEF.md
# Strobed Parallel Byte Demultiplexer

This block sits behind an asynchronous 8-bit parallel host port. The host drives the data lines and then releases an active-low strobe. Each release of the strobe hands one byte to the block. The block splits the resulting byte stream over four MIDI output channels. No start marker is used. The channels are implied by strict rotation: channel index 0, then 1, 2 and 3. Each channel's turn opens with a length byte, and that many payload bytes follow it. A length of zero skips the channel. Because of this, four zero-valued strobes sent while the block waits for channel 0's length bring the block back to that same point. The host uses this as its resynchronising reset.

Each payload byte is presented on a byte output together with its 2-bit channel index and a single-cycle valid pulse. The pulse waits for that channel's ready input. The block drives a BUSY line back to the host. BUSY is high while a payload byte waits for its channel. BUSY also goes high when the rotation wraps from channel 3 back to channel 0, and stays high for a programmable number of clock cycles. A host that samples BUSY after a transfer reads low as ready and high as not ready.

States of the framing machine: `ST_LEN` waits for the current channel's length byte. `ST_DATA` waits for the next payload byte. `ST_SEND` presents a held payload byte until the channel accepts it. Transitions:
- `ST_LEN` to `ST_DATA` on a non-zero length.
- `ST_LEN` to `ST_LEN` on a zero length. This advances the channel.
- `ST_DATA` to `ST_SEND` on any byte.
- `ST_SEND` to `ST_DATA` on acceptance when bytes remain.
- `ST_SEND` to `ST_LEN` on acceptance of the last byte. This advances the channel.

Top module: `pdmx_top`

## Requirements
- R1: A synchronous reset (`rst_i` high at a clock edge) puts the block in `ST_LEN` for channel index 0, with `busy_o` low and `out_vld_o` low. A frame interrupted by reset is abandoned.
- R2: Exactly one byte is taken for each low-to-high transition of `strb_n_i`, whatever the length of the low or high phase, provided each phase lasts at least three clock cycles. The byte taken is the value on `data_i`, which is held stable around the transition.
- R3: Channels are served in index order 0, 1, 2, 3, and then 0 again. `out_chan_o` carries the index of the channel that owns the byte.
- R4: The first byte taken in each channel's turn is its length (0 to 255). A length byte never appears on `out_byte_o` with `out_vld_o` high.
- R5: Each of the N payload bytes after a non-zero length appears exactly once, in order, on `out_byte_o`. Each appears with a one-cycle `out_vld_o` pulse and the current channel index.
- R6: A length of zero produces no output, and the next byte taken is the following channel's length.
- R7: After channel index 3's turn ends, the block waits for channel index 0's length. Four zero bytes taken from that state produce no output and return to it.
- R8: On a wrap from channel 3 to channel 0, `busy_o` is high no later than five clock edges after the strobe's rising transition. It stays high for BUSY_HOLD cycles after the wrap, and then goes low.
- R9: While a payload byte is held and `ch_rdy_i[channel]` is low, `out_vld_o` stays low and `busy_o` stays high. The byte is delivered in the cycle in which ready is high. Strobes that arrive while a byte is held are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_i | input | 1 | Synchronous reset, active high |
| strb_n_i | input | 1 | Host strobe, active low, asynchronous |
| data_i | input | 8 | Host data lines, asynchronous |
| ch_rdy_i | input | 4 | Per-channel ready, bit n for channel index n |
| busy_o | output | 1 | Handshake to host, high means not ready |
| out_byte_o | output | 8 | Payload byte |
| out_chan_o | output | 2 | Channel index of the payload byte |
| out_vld_o | output | 1 | One-cycle qualifier for the payload byte |

## Verification
The main sweep runs all 256 combinations of per-channel lengths 0 to 3. Payload values in this sweep are computed from the frame, channel and position, and the strobe low phase varies from frame to frame. The sweep tells apart errors in three areas: length-versus-payload classification, channel advance after zero and non-zero lengths, and byte ordering. A bare four-zero sequence from idle shows that the resync pattern emits nothing and leaves the rotation aligned. A stalled channel with a held byte separates the ready gating from the BUSY stretch. A reset in the middle of a frame shows that partial framing state is discarded.

// File: rtl/pdmx_pkg.sv
package pdmx_pkg;

    typedef enum logic [1:0] {
        ST_LEN  = 2'd0,
        ST_DATA = 2'd1,
        ST_SEND = 2'd2
    } frm_state_t;

endpackage

// File: rtl/pdmx_sync_edge.sv
module pdmx_sync_edge #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              strb_n_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              take_o,
    output logic [DATA_W-1:0] data_o
);

    logic [STAGES-1:0] strb_pipe;
    logic [DATA_W-1:0] data_pipe [STAGES];
    logic              strb_prev;

    // Synchroniser chains; strobe rests high so it resets high
    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk_i) begin
                    if (rst_i) begin
                        strb_pipe[0] <= 1'b1;
                        data_pipe[0] <= '0;
                    end else begin
                        strb_pipe[0] <= strb_n_i;
                        data_pipe[0] <= data_i;
                    end
                end
            end else begin : g_next
                always_ff @(posedge clk_i) begin
                    if (rst_i) begin
                        strb_pipe[g] <= 1'b1;
                        data_pipe[g] <= '0;
                    end else begin
                        strb_pipe[g] <= strb_pipe[g-1];
                        data_pipe[g] <= data_pipe[g-1];
                    end
                end
            end
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (rst_i) strb_prev <= 1'b1;
        else       strb_prev <= strb_pipe[STAGES-1];
    end

    assign take_o = strb_pipe[STAGES-1] & ~strb_prev;
    assign data_o = data_pipe[STAGES-1];

    // R2: a rising transition yields a single take
    p_take_single_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        take_o |=> !take_o);

endmodule

// File: rtl/pdmx_frame_fsm.sv
module pdmx_frame_fsm
    import pdmx_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned CH_W   = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              take_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic [NUM_CH-1:0] ch_rdy_i,
    output logic [DATA_W-1:0] out_byte_o,
    output logic [CH_W-1:0]   out_chan_o,
    output logic              out_vld_o,
    output logic              stall_o,
    output logic              wrap_o
);

    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

    frm_state_t        state_q, state_d;
    logic [CH_W-1:0]   chan_q, chan_d;
    logic [DATA_W-1:0] left_q, left_d;
    logic [DATA_W-1:0] hold_q, hold_d;
    logic [CH_W-1:0]   chan_inc;
    logic              chan_last;
    logic              sel_rdy;

    assign chan_last = (chan_q == LAST_CH);
    assign chan_inc  = chan_last ? '0 : chan_q + 1'b1;
    assign sel_rdy   = ch_rdy_i[chan_q];

    // State register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_LEN;
            chan_q  <= '0;
            left_q  <= '0;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            chan_q  <= chan_d;
            left_q  <= left_d;
            hold_q  <= hold_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        chan_d  = chan_q;
        left_d  = left_q;
        hold_d  = hold_q;
        wrap_o  = 1'b0;
        unique case (state_q)
            ST_LEN: begin
                if (take_i) begin
                    if (byte_i == '0) begin
                        chan_d = chan_inc;
                        wrap_o = chan_last;
                    end else begin
                        left_d  = byte_i;
                        state_d = ST_DATA;
                    end
                end
            end
            ST_DATA: begin
                if (take_i) begin
                    hold_d  = byte_i;
                    state_d = ST_SEND;
                end
            end
            ST_SEND: begin
                if (sel_rdy) begin
                    left_d = left_q - 1'b1;
                    if (left_q == DATA_W'(1)) begin
                        state_d = ST_LEN;
                        chan_d  = chan_inc;
                        wrap_o  = chan_last;
                    end else begin
                        state_d = ST_DATA;
                    end
                end
            end
            default: state_d = ST_LEN;
        endcase
    end

    // Outputs
    always_comb begin
        out_byte_o = hold_q;
        out_chan_o = chan_q;
        stall_o    = (state_q == ST_SEND);
        out_vld_o  = (state_q == ST_SEND) && sel_rdy;
    end

    // R3: channel moves only one step forward, wrapping after the last
    p_chan_step_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (chan_q != $past(chan_q)) |->
        (chan_q == (($past(chan_q) == LAST_CH) ? '0 : $past(chan_q) + 1'b1)));

    // R4: nothing is emitted while a length is awaited
    p_len_silent_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_LEN) |-> !out_vld_o);

    // R5: valid is a single-cycle pulse
    p_vld_pulse_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        out_vld_o |=> !out_vld_o);

endmodule

// File: rtl/pdmx_busy_timer.sv
module pdmx_busy_timer #(
    parameter int unsigned HOLD = 16
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic wrap_i,
    input  logic stall_i,
    output logic busy_o
);

    localparam int unsigned CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] HOLD_V = CW'(HOLD);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)              cnt_q <= '0;
        else if (wrap_i)        cnt_q <= HOLD_V;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign busy_o = (cnt_q != '0) | stall_i;

    // R8: a wrap raises busy on the following cycle
    p_busy_on_wrap_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        wrap_i |=> busy_o);

endmodule

// File: rtl/pdmx_top.sv
module pdmx_top #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned NUM_CH      = 4,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned BUSY_HOLD   = 16,
    localparam int unsigned CH_W       = $clog2(NUM_CH)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              strb_n_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [NUM_CH-1:0] ch_rdy_i,
    output logic              busy_o,
    output logic [DATA_W-1:0] out_byte_o,
    output logic [CH_W-1:0]   out_chan_o,
    output logic              out_vld_o
);

    logic              take;
    logic [DATA_W-1:0] byte_s;
    logic              stall;
    logic              wrap;

    pdmx_sync_edge #(.DATA_W(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .strb_n_i (strb_n_i),
        .data_i   (data_i),
        .take_o   (take),
        .data_o   (byte_s)
    );

    pdmx_frame_fsm #(.DATA_W(DATA_W), .NUM_CH(NUM_CH), .CH_W(CH_W)) u_fsm (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .take_i     (take),
        .byte_i     (byte_s),
        .ch_rdy_i   (ch_rdy_i),
        .out_byte_o (out_byte_o),
        .out_chan_o (out_chan_o),
        .out_vld_o  (out_vld_o),
        .stall_o    (stall),
        .wrap_o     (wrap)
    );

    pdmx_busy_timer #(.HOLD(BUSY_HOLD)) u_busy (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .wrap_i  (wrap),
        .stall_i (stall),
        .busy_o  (busy_o)
    );

    // R9: a held byte keeps busy high at the port
    p_stall_busy_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (stall && !out_vld_o) |-> busy_o);

endmodule

// File: tb/pdmx_top_tb_top.sv
`timescale 1ns/1ps
module pdmx_top_tb_top;

    localparam int HOLD = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       strb_n = 1'b1;
    logic [7:0] data = 8'h00;
    logic [3:0] rdy = 4'hF;
    logic       busy;
    logic [7:0] ob;
    logic [1:0] oc;
    logic       ov;

    int total = 0;
    int bad = 0;
    int got_n = 0;
    logic [7:0] got_b [16];
    logic [1:0] got_c [16];
    logic [7:0] exp_b [16];
    logic [1:0] exp_c [16];

    always #2.5 clk = ~clk;

    pdmx_top #(.BUSY_HOLD(HOLD)) dut_i (
        .clk_i (clk), .rst_i (rst), .strb_n_i (strb_n), .data_i (data),
        .ch_rdy_i (rdy), .busy_o (busy), .out_byte_o (ob),
        .out_chan_o (oc), .out_vld_o (ov)
    );

    always @(negedge clk) begin
        if (!rst && ov) begin
            if (got_n < 16) begin
                got_b[got_n] = ob;
                got_c[got_n] = oc;
            end
            got_n = got_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic put_byte(input logic [7:0] b, input int low_w);
        @(posedge clk); #1;
        data = b;
        cyc(2);
        strb_n = 1'b0;
        cyc(low_w);
        strb_n = 1'b1;
        cyc(6);
    endtask

    task automatic check_busy_window(input string req);
        @(negedge clk);
        chk(busy === 1'b1, req, busy, 1);
        cyc(10);
        @(negedge clk);
        chk(busy === 1'b1, req, busy, 1);
        cyc(12);
        @(negedge clk);
        chk(busy === 1'b0, req, busy, 0);
    endtask

    task automatic run_frame(input int f, input int low_w);
        int n = 0;
        int eb, ec;
        got_n = 0;
        for (int ch = 0; ch < 4; ch++) begin
            int len = (f >> (2 * ch)) & 3;
            put_byte(8'(len), low_w);
            for (int k = 0; k < len; k++) begin
                logic [7:0] v = 8'((f * 7 + ch * 31 + k * 3 + 1) & 255);
                exp_b[n] = v;
                exp_c[n] = 2'(ch);
                n++;
                put_byte(v, low_w);
            end
        end
        @(negedge clk);
        chk(got_n == n, "R4 R6 byte count", got_n, n);
        eb = 0; ec = 0;
        for (int i = 0; i < n && i < got_n; i++) begin
            if (got_b[i] !== exp_b[i]) eb++;
            if (got_c[i] !== exp_c[i]) ec++;
        end
        chk(eb == 0, "R5 R2 payload values", eb, 0);
        chk(ec == 0, "R3 channel order", ec, 0);
        check_busy_window("R8 R7 busy after wrap");
    endtask

    initial begin
        #750000;
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cyc(4);
        @(negedge clk);
        chk(busy === 1'b0, "R1 busy in reset", busy, 0);
        chk(ov === 1'b0, "R1 valid in reset", ov, 0);
        rst = 1'b0;
        cyc(3);
        @(negedge clk);
        chk(busy === 1'b0, "R1 busy after reset", busy, 0);

        // R7: bare resync pattern from idle
        got_n = 0;
        for (int i = 0; i < 4; i++) put_byte(8'h00, 3);
        @(negedge clk);
        chk(got_n == 0, "R7 no output on resync", got_n, 0);
        check_busy_window("R7 R8 busy on resync");

        // R1: reset in the middle of a frame
        put_byte(8'd3, 3);
        put_byte(8'h77, 3);
        @(posedge clk); #1;
        rst = 1'b1;
        cyc(2);
        rst = 1'b0;
        cyc(2);
        run_frame(8'b01_00_10_01, 3);

        // Main sweep: every length mix 0..3 per channel, varied low phase (R2)
        for (int f = 0; f < 256; f++) run_frame(f, 3 + (f % 5));

        // R9: stalled channel 1
        got_n = 0;
        rdy = 4'b1101;
        put_byte(8'd0, 3);
        put_byte(8'd2, 3);
        put_byte(8'hA5, 3);
        @(negedge clk);
        chk(busy === 1'b1, "R9 busy while held", busy, 1);
        put_byte(8'h3C, 3);
        cyc(10);
        @(negedge clk);
        chk(got_n == 0, "R9 no valid while not ready", got_n, 0);
        chk(busy === 1'b1, "R9 busy still high", busy, 1);
        @(posedge clk); #1;
        rdy = 4'hF;
        cyc(2);
        @(negedge clk);
        chk(got_n == 1, "R9 single delivery", got_n, 1);
        chk(got_b[0] == 8'hA5, "R9 held byte", int'(got_b[0]), 8'hA5);
        chk(got_c[0] == 2'd1, "R9 held channel", int'(got_c[0]), 1);
        put_byte(8'h5A, 3);
        put_byte(8'd0, 3);
        put_byte(8'd0, 3);
        @(negedge clk);
        chk(got_n == 2, "R9 strobe during hold dropped", got_n, 2);
        chk(got_b[1] == 8'h5A, "R9 second byte", int'(got_b[1]), 8'h5A);
        check_busy_window("R8 busy after stalled frame");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule